// File: doc/BRIEF.md
# Configuration Register with Capability Gating

This block holds one 8-bit configuration byte of a PCI network controller and derives from it the capability-related fields that the controller shows in PCI configuration space. The host reads and writes the byte through a simple write strobe and a combinational read value. A one-time load from the serial EEPROM sets selected fields after reset.

Two bits of the byte are not stored. They report live whether the operational registers are decoded in memory space and in I/O space. One bit records that the driver has loaded. It clears itself whenever the host writes the enable bits of the PCI command register, which the block sees as a snoop pulse.

The lowest bit switches the power-management capability in or out of configuration space. The host can change it only while the EEPROM mode input is at its unlock value. When it is set, the block presents:

- the capabilities-list status flag,
- a capability pointer,
- the power-management capability ID and next pointer,
- a validity flag for the power-management registers.

When it is clear, all of these read zero.

Top module: `cfg_cap_reg`

## Requirements
- R1: After reset, and before any EEPROM load, the stored bits read 0. `rd_data[3]` and `rd_data[2]` follow `mem_mapped` and `io_mapped`. All capability outputs are 0.
- R2: Bit 5 (driver loaded) reads back the value of `wr_data[5]` from the most recent host write, unless a snoop pulse intervened.
- R3: A pulse on `cmd_wr_snoop` clears bit 5 on the next clock edge. This holds even when a host write sets bit 5 in the same cycle.
- R4: `rd_data[3]` always equals `mem_mapped` and `rd_data[2]` always equals `io_mapped`. Host writes to these two bit positions have no effect.
- R5: A host write changes bit 0 (power-management enable) only when `ee_mode` is 2'b11. Under any other mode, bit 0 keeps its value.
- R6: While bit 0 is 0, the following are all 0: `cap_list_bit`, `cap_ptr`, `cap_id`, `next_ptr` and `pm_regs_valid`.
- R7: While bit 0 is 1, the outputs are:
  - `cap_list_bit` = 1
  - `cap_ptr` = 8'h50
  - `cap_id` = 8'h01
  - `next_ptr` = 8'h00
  - `pm_regs_valid` = 1
- R8: The first `ee_valid` cycle after reset copies bits 7, 6, 1 and 0 of `ee_data` into the byte, independent of `ee_mode`. Every later `ee_valid` until the next reset is ignored.
- R9: If a host write coincides with the EEPROM load, the host write decides every bit it is allowed to write.
- R10: Bits 7, 6 (LED mode), 4 (wake option) and 1 (VPD enable) are plain read/write bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write value |
| ee_valid | input | 1 | EEPROM image valid strobe |
| ee_data | input | 8 | EEPROM image of the byte |
| ee_mode | input | 2 | EEPROM mode bits; 2'b11 unlocks bit 0 |
| cmd_wr_snoop | input | 1 | Pulse: PCI command enable bits written |
| mem_mapped | input | 1 | Registers decoded in memory space |
| io_mapped | input | 1 | Registers decoded in I/O space |
| rd_data | output | 8 | Current register value |
| cap_list_bit | output | 1 | Capabilities-list status flag |
| cap_ptr | output | 8 | Capability pointer |
| cap_id | output | 8 | Power-management capability ID |
| next_ptr | output | 8 | Next capability pointer |
| pm_regs_valid | output | 1 | Power-management registers valid |

## Verification
The bench builds the block with its default parameters:

- reset value 0,
- EEPROM load mask 8'hC3,
- unlock mode 2'b11,
- capability base 8'h50 with ID 8'h01.

These values make the load-once rule, the write lock on bit 0, and the collision of the snoop pulse with a write to bit 5 reachable in a short directed sequence. A second reset reopens the load window, so the load coinciding with a host write can be tested. A randomized phase then mixes writes, loads, snoops and mode changes, and compares every cycle against the behavioural model.

// File: rtl/cfgcap_pkg.sv
package cfgcap_pkg;

    localparam int unsigned CFG_W = 8;

    // Bit positions whose meaning other logic decodes
    localparam int unsigned BIT_PM  = 0;
    localparam int unsigned BIT_IO  = 2;
    localparam int unsigned BIT_MEM = 3;
    localparam int unsigned BIT_DRV = 5;

    // Stored bits: everything except the two live status bits
    localparam logic [CFG_W-1:0] STORE_MASK = ~((CFG_W'(1) << BIT_MEM) | (CFG_W'(1) << BIT_IO));
    localparam logic [CFG_W-1:0] PM_MASK    = CFG_W'(1) << BIT_PM;
    localparam logic [CFG_W-1:0] DRV_MASK   = CFG_W'(1) << BIT_DRV;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } core_state_t;

    typedef struct packed {
        logic done;
    } load_state_t;

    typedef struct packed {
        logic             list_bit;
        logic [CFG_W-1:0] ptr;
        logic [CFG_W-1:0] id;
        logic [CFG_W-1:0] next;
        logic             valid;
    } cap_view_t;

endpackage

// File: rtl/cfgcap_loader.sv
module cfgcap_loader (
    input  logic clk,
    input  logic rst_n,
    input  logic ee_valid,
    output logic load_stb
);
    import cfgcap_pkg::*;

    load_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        load_stb = ee_valid & ~st_q.done;
        if (load_stb) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb) else $error("load strobe repeated"); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done) else $error("load window reopened"); // R8

endmodule

// File: rtl/cfgcap_core.sv
module cfgcap_core #(
    parameter int unsigned            W         = 8,
    parameter logic [W-1:0]           RST_VAL   = '0,
    parameter logic [W-1:0]           LOAD_MASK = 8'hC3,
    parameter logic [1:0]             PM_UNLOCK = 2'b11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load_stb,
    input  logic [W-1:0] ee_data,
    input  logic [1:0]   ee_mode,
    input  logic         cmd_wr_snoop,
    output logic [W-1:0] cfg_q_o
);
    import cfgcap_pkg::*;

    localparam logic [W-1:0] LD_M   = LOAD_MASK & STORE_MASK;
    localparam logic [W-1:0] RST_M  = RST_VAL & STORE_MASK;

    core_state_t  st_d, st_q;
    logic [W-1:0] wr_mask;
    logic         pm_unlocked;

    always_comb begin
        st_d        = st_q;
        pm_unlocked = (ee_mode == PM_UNLOCK);
        wr_mask     = pm_unlocked ? STORE_MASK : (STORE_MASK & ~PM_MASK);
        // EEPROM image first, host write over it, auto-clear last
        if (load_stb) begin
            st_d.cfg = (st_d.cfg & ~LD_M) | (ee_data & LD_M);
        end
        if (wr_en) begin
            st_d.cfg = (st_d.cfg & ~wr_mask) | (wr_data & wr_mask);
        end
        if (cmd_wr_snoop) begin
            st_d.cfg = st_d.cfg & ~DRV_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: RST_M};
        else        st_q <= st_d;
    end

    assign cfg_q_o = st_q.cfg;

    AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_snoop |=> !cfg_q_o[BIT_DRV]) else $error("drv bit not cleared"); // R3

    AST_DRV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cmd_wr_snoop) |=> cfg_q_o[BIT_DRV] == $past(wr_data[BIT_DRV]))
        else $error("drv bit write lost"); // R2

    AST_PM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ee_mode != PM_UNLOCK && !load_stb) |=> $stable(cfg_q_o[BIT_PM]))
        else $error("pm bit changed while locked"); // R5

endmodule

// File: rtl/cfgcap_capview.sv
module cfgcap_capview #(
    parameter int unsigned  W         = 8,
    parameter logic [W-1:0] CAP_BASE  = 8'h50,
    parameter logic [W-1:0] PM_CAP_ID = 8'h01,
    parameter logic [W-1:0] NEXT_CAP  = 8'h00
) (
    input  logic                 pm_en,
    output cfgcap_pkg::cap_view_t view
);
    always_comb begin
        view = '0;
        if (pm_en) begin
            view.list_bit = 1'b1;
            view.ptr      = CAP_BASE;
            view.id       = PM_CAP_ID;
            view.next     = NEXT_CAP;
            view.valid    = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_cap_reg.sv
module cfg_cap_reg #(
    parameter logic [7:0] RST_VAL   = 8'h00,
    parameter logic [7:0] LOAD_MASK = 8'hC3,
    parameter logic [1:0] PM_UNLOCK = 2'b11,
    parameter logic [7:0] CAP_BASE  = 8'h50,
    parameter logic [7:0] PM_CAP_ID = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ee_valid,
    input  logic [7:0] ee_data,
    input  logic [1:0] ee_mode,
    input  logic       cmd_wr_snoop,
    input  logic       mem_mapped,
    input  logic       io_mapped,
    output logic [7:0] rd_data,
    output logic       cap_list_bit,
    output logic [7:0] cap_ptr,
    output logic [7:0] cap_id,
    output logic [7:0] next_ptr,
    output logic       pm_regs_valid
);
    import cfgcap_pkg::*;

    logic                 load_stb;
    logic [CFG_W-1:0]     cfg_q;
    cap_view_t            view;

    cfgcap_loader u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .ee_valid (ee_valid),
        .load_stb (load_stb)
    );

    cfgcap_core #(
        .W         (CFG_W),
        .RST_VAL   (RST_VAL),
        .LOAD_MASK (LOAD_MASK),
        .PM_UNLOCK (PM_UNLOCK)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .load_stb     (load_stb),
        .ee_data      (ee_data),
        .ee_mode      (ee_mode),
        .cmd_wr_snoop (cmd_wr_snoop),
        .cfg_q_o      (cfg_q)
    );

    cfgcap_capview #(
        .W         (CFG_W),
        .CAP_BASE  (CAP_BASE),
        .PM_CAP_ID (PM_CAP_ID),
        .NEXT_CAP  (8'h00)
    ) u_view (
        .pm_en (cfg_q[BIT_PM]),
        .view  (view)
    );

    always_comb begin
        rd_data          = cfg_q & STORE_MASK;
        rd_data[BIT_MEM] = mem_mapped;
        rd_data[BIT_IO]  = io_mapped;
    end

    assign cap_list_bit  = view.list_bit;
    assign cap_ptr       = view.ptr;
    assign cap_id        = view.id;
    assign next_ptr      = view.next;
    assign pm_regs_valid = view.valid;

    AST_CAP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[BIT_PM] |-> (cap_ptr == 8'h00 && cap_id == 8'h00 && !cap_list_bit && !pm_regs_valid))
        else $error("capability visible while disabled"); // R6

    AST_CAP_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_PM] |-> (cap_ptr == CAP_BASE && cap_id == PM_CAP_ID && next_ptr == 8'h00 && cap_list_bit))
        else $error("capability fields wrong while enabled"); // R7

endmodule

// File: tb/tb_cfg_cap_reg.sv
module tb_cfg_cap_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ee_valid = 1'b0;
    logic [7:0] ee_data = '0;
    logic [1:0] ee_mode = '0;
    logic       cmd_wr_snoop = 1'b0;
    logic       mem_mapped = 1'b1;
    logic       io_mapped = 1'b0;
    logic [7:0] rd_data;
    logic       cap_list_bit;
    logic [7:0] cap_ptr, cap_id, next_ptr;
    logic       pm_regs_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference
    int mdl_reg    = 0;
    bit mdl_loaded = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_cap_reg dut (.*);

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int exp_rd;
        bit pm;
        exp_rd = (mdl_reg & 8'hF3) | (int'(mem_mapped) << 3) | (int'(io_mapped) << 2);
        pm = mdl_reg[0];
        check(req, int'(rd_data), exp_rd, "rd_data");
        check(pm ? "R7" : "R6",
              {cap_list_bit, cap_ptr, cap_id, next_ptr, pm_regs_valid},
              pm ? {1'b1, 8'h50, 8'h01, 8'h00, 1'b1} : 0, "cap fields");
    endtask

    // drive one cycle of stimulus, advance model, compare after edge
    task automatic step(input string req, input bit w, input logic [7:0] wd,
                        input logic [1:0] mode, input bit snp, input bit ev,
                        input logic [7:0] ed);
        wr_en = w; wr_data = wd; ee_mode = mode; cmd_wr_snoop = snp;
        ee_valid = ev; ee_data = ed;
        @(posedge clk);
        if (ev && !mdl_loaded) begin
            mdl_reg = (mdl_reg & ~8'hC3) | (int'(ed) & 8'hC3);
            mdl_loaded = 1;
        end
        if (w) begin
            int m;
            m = (mode == 2'b11) ? 8'hF3 : 8'hF2;
            mdl_reg = (mdl_reg & ~m) | (int'(wd) & m);
        end
        if (snp) mdl_reg = mdl_reg & ~8'h20;
        @(negedge clk);
        wr_en = 0; cmd_wr_snoop = 0; ee_valid = 0;
        compare(req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        mdl_reg = 0; mdl_loaded = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        compare("R1");                                       // R1 reset state
        step("R10", 1, 8'hFF, 2'b00, 0, 0, 8'h00);            // R10, R5 bit0 locked
        step("R5",  1, 8'h01, 2'b01, 0, 0, 8'h00);            // R5 still locked
        step("R8",  0, 8'h00, 2'b00, 0, 1, 8'h41);            // R8 first load
        step("R8",  0, 8'h00, 2'b00, 0, 1, 8'hC2);            // R8 later load ignored
        step("R5",  1, 8'h00, 2'b10, 0, 0, 8'h00);            // R5 pm held
        step("R5",  1, 8'h00, 2'b11, 0, 0, 8'h00);            // R5 unlocked -> R6
        step("R2",  1, 8'h21, 2'b11, 0, 0, 8'h00);            // R2 drv set, pm on
        step("R3",  0, 8'h00, 2'b00, 1, 0, 8'h00);            // R3 snoop clears
        step("R2",  1, 8'h20, 2'b00, 0, 0, 8'h00);            // R2
        step("R3",  1, 8'h20, 2'b00, 1, 0, 8'h00);            // R3 snoop beats write
        mem_mapped = 0; io_mapped = 1;
        step("R4",  1, 8'h0C, 2'b00, 0, 0, 8'h00);            // R4 status bits live
        mem_mapped = 1; io_mapped = 1;
        step("R4",  1, 8'h00, 2'b00, 0, 0, 8'h00);            // R4
        step("R10", 1, 8'hD2, 2'b00, 0, 0, 8'h00);            // R10 plain bits
        do_reset();
        compare("R1");
        step("R9",  1, 8'h00, 2'b11, 0, 1, 8'hC3);            // R9 write beats load
        step("R8",  0, 8'h00, 2'b00, 0, 1, 8'hC3);            // R8 window closed
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            mem_mapped = r[20]; io_mapped = r[21];
            step("R10", r[0], r[15:8], r[2:1], r[3] & r[4], r[5] & r[6] & r[7], r[31:24]);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule